// File: doc/BRIEF.md
# Graphics DDR DRAM Power-Up Initialization Sequencer

This block sits on the controller side of a graphics DDR DRAM interface. It owns the command pins from reset until the memory is ready for normal traffic. It keeps the clock-enable pin low while the clock settles. It then raises clock enable with a NOP and steps through a fixed list of commands: precharge-all, DLL enable in the extended mode register, DLL reset in the mode register, a second precharge-all, a run of auto-refreshes, and a final mode-register load. Each command is followed by the gap that the memory needs.

The DLL needs time to lock after its reset. That lock interval is counted by a separate counter, which runs while the later commands are issued. The completion flag rises only when the command list has finished and the lock interval has also expired. After that, the normal scheduler takes over the command bus, and the sequencer drives only NOPs.

The operating CAS latency, burst length and burst ordering come in as raw mode-register codes. They are placed into the address field of both mode-register writes.

Top module: `gddr_init_seq`

## Requirements
- R1: From reset, `cke` stays low for exactly `STABLE_CYC` clock cycles. It then rises in a cycle that carries a NOP, and it stays high until the next reset.
- R2: The first command after `cke` rises is issued one cycle later. It is a precharge-all, encoded as `cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=0 with `addr[10]`=1.
- R3: The second command writes the extended mode register: all four command pins low, `ba`=1 (bit 0 set), and `addr` all zero. `addr[0]`=0 enables the DLL.
- R4: The third command writes the mode register with `ba`=0 and `addr[8]`=1 (DLL reset). It also carries `addr[2:0]`=`cfg_burst_len`, `addr[3]`=`cfg_burst_intlv` and `addr[6:4]`=`cfg_cas_lat`. All other address bits are zero.
- R5: Next come a second precharge-all and then exactly `N_REFRESH` auto-refresh commands, encoded as `cs_n`=0, `ras_n`=0, `cas_n`=0, `we_n`=1. A full sequence therefore has `5+N_REFRESH` commands.
- R6: The last command is a mode-register write with `ba`=0 and `addr[8]`=0. Its field positions for the configuration codes are the same as in R4.
- R7: The next command follows exactly `T_RP` cycles after a precharge-all, `T_MRD` cycles after any mode or extended-mode write, and `T_RFC` cycles after a refresh.
- R8: Every cycle without a command is a NOP: `cs_n`=0, `ras_n`=`cas_n`=`we_n`=1, with `ba` and `addr` zero. No command is issued while `cke` is low or once `init_done` is high.
- R9: `init_done` rises one cycle after the later of two points: `T_MRD` cycles after the final mode write, and `DLL_LOCK` cycles after the DLL-reset write. It then stays high until reset, even if the configuration inputs change.
- R10: An active-low `rst_n` forces `cke` low, a NOP and `init_done` low at once, even in the middle of the sequence. The whole sequence restarts from the stable-clock wait after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cas_lat | input | 3 | CAS latency code for mode bits 6:4 |
| cfg_burst_len | input | 3 | Burst length code for mode bits 2:0 |
| cfg_burst_intlv | input | 1 | Burst ordering for mode bit 3 (1 = interleaved) |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address / mode-register field |
| init_done | output | 1 | Initialization complete; bus handed over |

## Verification
The assertions assume that `rst_n` is low from time zero and that the configuration inputs reach only the address field. Nothing in the command timing or the completion check depends on their values. The bench holds reset low from the first instant. It applies only legal latency and burst codes taken from its vector table. When it changes the configuration after completion, it does so only to confirm that the bus stays quiet. A mid-sequence reset is applied between clock edges, so the asynchronous clear is observed without racing an edge.

// File: rtl/init_pkg.sv
package init_pkg;

   typedef enum logic [3:0] {
      ST_STABLE, ST_CKE, ST_PRE1, ST_EMRS, ST_MRS_DLL,
      ST_PRE2, ST_REF, ST_MRS_OP, ST_HOLD, ST_DONE
   } step_e;

   typedef enum logic [2:0] {
      C_NOP, C_PREA, C_EMRS, C_MRS_DLL, C_MRS_OP, C_REF
   } cmd_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } pins_t;

   function automatic pins_t cmd_pins(cmd_e c);
      pins_t p;
      case (c)
         C_PREA:                      p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
         C_EMRS, C_MRS_DLL, C_MRS_OP: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
         C_REF:                       p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
         default:                     p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
      endcase
      return p;
   endfunction

   function automatic int unsigned max2(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/init_step_timer.sv
module init_step_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else          cnt <= cnt + W'(1);
   end
endmodule

// File: rtl/init_lock_wait.sv
module init_lock_wait #(
   parameter int unsigned LIMIT = 200,
   localparam int unsigned W    = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic done
);
   logic         run_q;
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (start) begin
         run_q <= 1'b1;
         cnt_q <= W'(1);
      end else if (run_q && (cnt_q != W'(LIMIT))) begin
         cnt_q <= cnt_q + W'(1);
      end
   end

   assign done = run_q && (cnt_q == W'(LIMIT));
endmodule

// File: rtl/init_cmd_enc.sv
module init_cmd_enc
   import init_pkg::*;
#(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned BA_W   = 2
) (
   input  cmd_e              cmd,
   input  logic [2:0]        cfg_cas_lat,
   input  logic [2:0]        cfg_burst_len,
   input  logic              cfg_burst_intlv,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr
);
   pins_t               pins;
   logic [ADDR_W-1:0]   mode_field;

   always_comb begin
      mode_field      = '0;
      mode_field[2:0] = cfg_burst_len;
      mode_field[3]   = cfg_burst_intlv;
      mode_field[6:4] = cfg_cas_lat;
   end

   always_comb begin
      pins = cmd_pins(cmd);
      ba   = '0;
      addr = '0;
      case (cmd)
         C_PREA:    addr[10] = 1'b1;
         C_EMRS:    ba[0]    = 1'b1;
         C_MRS_DLL: begin
            addr    = mode_field;
            addr[8] = 1'b1;
         end
         C_MRS_OP:  addr = mode_field;
         default:   ;
      endcase
   end

   assign cs_n  = pins.cs_n;
   assign ras_n = pins.ras_n;
   assign cas_n = pins.cas_n;
   assign we_n  = pins.we_n;
endmodule

// File: rtl/gddr_init_seq.sv
module gddr_init_seq
   import init_pkg::*;
#(
   parameter int unsigned STABLE_CYC = 40000,
   parameter int unsigned T_RP       = 5,
   parameter int unsigned T_MRD      = 2,
   parameter int unsigned T_RFC      = 17,
   parameter int unsigned DLL_LOCK   = 200,
   parameter int unsigned N_REFRESH  = 2,
   parameter int unsigned ADDR_W     = 13,
   parameter int unsigned BA_W       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cfg_cas_lat,
   input  logic [2:0]        cfg_burst_len,
   input  logic              cfg_burst_intlv,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr,
   output logic              init_done
);
   localparam int unsigned DUR_MAX = max2(max2(STABLE_CYC, T_RFC), max2(T_RP, T_MRD));
   localparam int unsigned TMR_W   = $clog2(DUR_MAX + 1);
   localparam int unsigned REF_W   = $clog2(N_REFRESH + 1);

   generate
      if (T_MRD < 2)        begin : g_bad_mrd  $error("T_MRD must be at least 2"); end
      if (N_REFRESH < 2)    begin : g_bad_ref  $error("N_REFRESH must be at least 2"); end
      if (STABLE_CYC < 1)   begin : g_bad_stab $error("STABLE_CYC must be nonzero"); end
      if (DLL_LOCK < 1)     begin : g_bad_lock $error("DLL_LOCK must be nonzero"); end
      if (ADDR_W < 11)      begin : g_bad_addr $error("ADDR_W must reach bit 10"); end
      if (BA_W < 1)         begin : g_bad_ba   $error("BA_W must be nonzero"); end
   endgenerate

   step_e              step_q, step_d;
   logic [TMR_W-1:0]   tmr, dur;
   logic [REF_W-1:0]   ref_q;
   logic               first, last, adv, lock_start, lock_done;
   cmd_e               cmd;

   init_step_timer #(.W(TMR_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (adv),
      .cnt   (tmr)
   );

   always_comb begin
      case (step_q)
         ST_STABLE:                      dur = TMR_W'(STABLE_CYC);
         ST_PRE1, ST_PRE2:               dur = TMR_W'(T_RP);
         ST_EMRS, ST_MRS_DLL, ST_MRS_OP: dur = TMR_W'(T_MRD);
         ST_REF:                         dur = TMR_W'(T_RFC);
         default:                        dur = TMR_W'(1);
      endcase
   end

   assign first = (tmr == '0);
   assign last  = (tmr == dur - TMR_W'(1));

   always_comb begin
      case (step_q)
         ST_HOLD: adv = lock_done;
         ST_DONE: adv = 1'b0;
         default: adv = last;
      endcase
   end

   always_comb begin
      step_d = step_q;
      if (adv) begin
         case (step_q)
            ST_STABLE:  step_d = ST_CKE;
            ST_CKE:     step_d = ST_PRE1;
            ST_PRE1:    step_d = ST_EMRS;
            ST_EMRS:    step_d = ST_MRS_DLL;
            ST_MRS_DLL: step_d = ST_PRE2;
            ST_PRE2:    step_d = ST_REF;
            ST_REF:     step_d = (ref_q == REF_W'(N_REFRESH - 1)) ? ST_MRS_OP : ST_REF;
            ST_MRS_OP:  step_d = ST_HOLD;
            ST_HOLD:    step_d = ST_DONE;
            default:    step_d = step_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= ST_STABLE;
         ref_q  <= '0;
      end else begin
         step_q <= step_d;
         if (step_q == ST_REF && adv) ref_q <= ref_q + REF_W'(1);
      end
   end

   always_comb begin
      cmd = C_NOP;
      if (first) begin
         case (step_q)
            ST_PRE1, ST_PRE2: cmd = C_PREA;
            ST_EMRS:          cmd = C_EMRS;
            ST_MRS_DLL:       cmd = C_MRS_DLL;
            ST_REF:           cmd = C_REF;
            ST_MRS_OP:        cmd = C_MRS_OP;
            default:          cmd = C_NOP;
         endcase
      end
   end

   assign lock_start = (step_q == ST_MRS_DLL) && first;

   init_lock_wait #(.LIMIT(DLL_LOCK)) u_lock (
      .clk   (clk),
      .rst_n (rst_n),
      .start (lock_start),
      .done  (lock_done)
   );

   init_cmd_enc #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_enc (
      .cmd             (cmd),
      .cfg_cas_lat     (cfg_cas_lat),
      .cfg_burst_len   (cfg_burst_len),
      .cfg_burst_intlv (cfg_burst_intlv),
      .cs_n            (cs_n),
      .ras_n           (ras_n),
      .cas_n           (cas_n),
      .we_n            (we_n),
      .ba              (ba),
      .addr            (addr)
   );

   assign cke       = (step_q != ST_STABLE);
   assign init_done = (step_q == ST_DONE);
endmodule

// File: rtl/init_seq_chk.sv
module init_seq_chk #(
   parameter int unsigned ADDR_W   = 13,
   parameter int unsigned BA_W     = 2,
   parameter int unsigned T_MRD    = 2,
   parameter int unsigned DLL_LOCK = 200
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cke,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [BA_W-1:0]   ba,
   input logic [ADDR_W-1:0] addr,
   input logic              init_done
);
   logic        is_nop, is_mode, is_prea, seen_q;
   int unsigned gap_q, lk_q;

   assign is_nop  = !cs_n && ras_n && cas_n && we_n;
   assign is_mode = !cs_n && !ras_n && !cas_n && !we_n;
   assign is_prea = !cs_n && !ras_n && cas_n && !we_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= T_MRD;
         lk_q   <= 0;
         seen_q <= 1'b0;
      end else begin
         if (is_mode)             gap_q <= 1;
         else if (gap_q < T_MRD)  gap_q <= gap_q + 1;
         if (is_mode && !ba[0] && addr[8]) begin
            seen_q <= 1'b1;
            lk_q   <= 1;
         end else if (seen_q && lk_q < DLL_LOCK) begin
            lk_q <= lk_q + 1;
         end
      end
   end

   p_cke_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cke |=> cke);
   p_prea_a10_r2: assert property (@(posedge clk) disable iff (!rst_n)
      is_prea |-> addr[10]);
   p_emrs_dll_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (is_mode && ba[0]) |-> !addr[0]);
   p_mrd_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !is_nop |-> (gap_q >= T_MRD));
   p_nop_cke_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |-> is_nop);
   p_quiet_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> (is_nop && cke));
   p_lock_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> (seen_q && lk_q >= DLL_LOCK));
   p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);
   p_reset_idle_r10: assert property (@(posedge clk)
      !rst_n |-> (!cke && !init_done && is_nop));
endmodule

bind gddr_init_seq init_seq_chk #(
   .ADDR_W(ADDR_W), .BA_W(BA_W), .T_MRD(T_MRD), .DLL_LOCK(DLL_LOCK)
) u_chk (.*);

// File: tb/gddr_init_seq_tb_top.sv
module gddr_init_seq_tb_top;
   localparam int STABLE = 20;
   localparam int TRP    = 5;
   localparam int TMRD   = 2;
   localparam int TRFC   = 17;
   localparam int LOCK   = 200;
   localparam int LOCK2  = 10;
   localparam int NREF   = 2;
   localparam logic [3:0] NOP4 = 4'b0111;

   // {cas_lat[2:0], burst_len[2:0], interleave, expected final mode address[12:0]}
   localparam logic [19:0] VEC [0:2] = '{
      {3'b011, 3'b010, 1'b0, 13'h032},
      {3'b100, 3'b011, 1'b1, 13'h04B},
      {3'b011, 3'b001, 1'b1, 13'h039}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cfg_cl = 3'b011, cfg_bl = 3'b010;
   logic        cfg_bt = 1'b0;
   logic        cke, cs_n, ras_n, cas_n, we_n, init_done;
   logic [1:0]  ba;
   logic [12:0] addr;
   logic        d2_cke, d2_cs_n, d2_ras_n, d2_cas_n, d2_we_n, d2_done;
   logic [1:0]  d2_ba;
   logic [12:0] d2_addr;

   always #10 clk = ~clk;

   gddr_init_seq #(.STABLE_CYC(STABLE), .T_RP(TRP), .T_MRD(TMRD), .T_RFC(TRFC),
                   .DLL_LOCK(LOCK), .N_REFRESH(NREF)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_cas_lat(cfg_cl), .cfg_burst_len(cfg_bl),
      .cfg_burst_intlv(cfg_bt), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done));

   gddr_init_seq #(.STABLE_CYC(STABLE), .T_RP(TRP), .T_MRD(TMRD), .T_RFC(TRFC),
                   .DLL_LOCK(LOCK2), .N_REFRESH(NREF)) dut2_i (
      .clk(clk), .rst_n(rst_n), .cfg_cas_lat(cfg_cl), .cfg_burst_len(cfg_bl),
      .cfg_burst_intlv(cfg_bt), .cke(d2_cke), .cs_n(d2_cs_n), .ras_n(d2_ras_n),
      .cas_n(d2_cas_n), .we_n(d2_we_n), .ba(d2_ba), .addr(d2_addr), .init_done(d2_done));

   int nchk = 0, nfail = 0, cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int          ev_cyc  [0:15];
   logic [3:0]  ev_cmd  [0:15];
   logic [12:0] ev_addr [0:15];
   logic [1:0]  ev_ba   [0:15];
   int          n_ev, low_cnt, rise_cyc, done_cyc, done2_cyc;
   bit          rise_nop, bad, p_cke, p_done, p_done2;

   always @(negedge clk) begin
      if (rst_n) begin
         logic [3:0] c4;
         c4 = {cs_n, ras_n, cas_n, we_n};
         if (cke && !p_cke) begin rise_cyc = cyc; rise_nop = (c4 == NOP4); end
         if (!cke) low_cnt++;
         if (c4 == NOP4) begin
            if (ba != 0 || addr != 0) bad = 1;
         end else begin
            if (!cke || init_done) bad = 1;
            if (n_ev < 16) begin
               ev_cyc[n_ev] = cyc; ev_cmd[n_ev] = c4;
               ev_addr[n_ev] = addr; ev_ba[n_ev] = ba;
            end
            n_ev++;
         end
         if (init_done && !p_done) done_cyc = cyc;
         if (d2_done && !p_done2) done2_cyc = cyc;
         p_cke = cke; p_done = init_done; p_done2 = d2_done;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_log();
      n_ev = 0; low_cnt = 0; rise_cyc = -1; done_cyc = -1; done2_cyc = -1;
      rise_nop = 0; bad = 0; p_cke = 0; p_done = 0; p_done2 = 0;
      for (int i = 0; i < 16; i++) begin
         ev_cyc[i] = 0; ev_cmd[i] = NOP4; ev_addr[i] = 0; ev_ba[i] = 0;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      clear_log();
      @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic wait_done();
      int t = 0;
      while (!(init_done && d2_done) && t < 3000) begin
         @(posedge clk); #1; t++;
      end
      chk(t < 3000, "R9 completion", t, 3000);
      repeat (3) @(posedge clk);
      #1;
   endtask

   function automatic int imax(int a, int b);
      return (a > b) ? a : b;
   endfunction

   task automatic check_run(input logic [12:0] exp_addr);
      int exp_gap [0:5];
      exp_gap = '{TRP, TMRD, TMRD, TRP, TRFC, TRFC};
      chk(low_cnt == STABLE, "R1 cke low cycles", low_cnt, STABLE);
      chk(rise_nop, "R1 NOP with cke rise", rise_nop, 1);
      chk(n_ev == 5 + NREF, "R5 command count", n_ev, 5 + NREF);
      chk(ev_cyc[0] == rise_cyc + 1, "R2 first command slot", ev_cyc[0], rise_cyc + 1);
      chk(ev_cmd[0] == 4'b0010 && ev_addr[0][10], "R2 precharge-all", ev_cmd[0], 2);
      chk(ev_cmd[1] == 4'b0000 && ev_ba[1] == 2'd1 && ev_addr[1] == 0,
          "R3 DLL enable write", ev_addr[1], 0);
      chk(ev_cmd[2] == 4'b0000 && ev_ba[2] == 2'd0 && ev_addr[2] == (exp_addr | 13'h100),
          "R4 DLL reset write", ev_addr[2], exp_addr | 13'h100);
      chk(ev_cmd[3] == 4'b0010 && ev_addr[3][10], "R5 second precharge-all", ev_cmd[3], 2);
      chk(ev_cmd[4] == 4'b0001 && ev_cmd[5] == 4'b0001, "R5 refreshes", ev_cmd[5], 1);
      chk(ev_cmd[6] == 4'b0000 && ev_ba[6] == 2'd0 && ev_addr[6] == exp_addr,
          "R6 final mode write", ev_addr[6], exp_addr);
      for (int i = 0; i < 6; i++)
         chk(ev_cyc[i+1] - ev_cyc[i] == exp_gap[i], "R7 command gap",
             ev_cyc[i+1] - ev_cyc[i], exp_gap[i]);
      chk(!bad, "R8 idle slots are NOP", bad, 0);
      chk(done_cyc == imax(ev_cyc[6] + TMRD, ev_cyc[2] + LOCK) + 1,
          "R9 done after lock wait", done_cyc, imax(ev_cyc[6] + TMRD, ev_cyc[2] + LOCK) + 1);
      chk(done2_cyc == imax(ev_cyc[6] + TMRD, ev_cyc[2] + LOCK2) + 1,
          "R9 done after command list", done2_cyc, imax(ev_cyc[6] + TMRD, ev_cyc[2] + LOCK2) + 1);
   endtask

   initial begin
      #(20 * 100000);
      chk(0, "R9 watchdog", 0, 1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      repeat (2) @(posedge clk);
      #1;
      chk(!cke && !init_done, "R10 reset state", {cke, init_done}, 0);
      chk({cs_n, ras_n, cas_n, we_n} == NOP4 && addr == 0, "R10 reset NOP",
          {cs_n, ras_n, cas_n, we_n}, NOP4);

      for (int v = 0; v < 3; v++) begin
         {cfg_cl, cfg_bl, cfg_bt} = VEC[v][19:13];
         do_reset();
         wait_done();
         check_run(VEC[v][12:0]);
      end

      // configuration changes after completion must not disturb the bus
      for (int k = 0; k < 20; k++) begin
         @(posedge clk); #1;
         cfg_cl = 3'(k); cfg_bl = 3'(k + 3); cfg_bt = k[0];
      end
      repeat (2) @(posedge clk);
      #1;
      chk(init_done && d2_done, "R9 done stays high", init_done, 1);
      chk(!bad, "R8 quiet after done", bad, 0);

      // reset in the middle of the sequence
      {cfg_cl, cfg_bl, cfg_bt} = VEC[0][19:13];
      do_reset();
      for (int t = 0; t < 500 && n_ev < 3; t++) begin
         @(posedge clk); #1;
      end
      chk(n_ev >= 3, "R10 mid-run point reached", n_ev, 3);
      #3 rst_n = 1'b0;
      #1;
      chk(!cke && !init_done, "R10 async clear", {cke, init_done}, 0);
      chk({cs_n, ras_n, cas_n, we_n} == NOP4 && addr == 0 && ba == 0, "R10 NOP in reset",
          {cs_n, ras_n, cas_n, we_n}, NOP4);
      do_reset();
      wait_done();
      check_run(VEC[0][12:0]);

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule